// File: doc/BRIEF.md
# Monitor User-Access Gate

This block holds the one-bit user-enable control that governs unprivileged access to a bank of activity-monitor counters. It also decides the outcome of each system-register request that selects this control, whether a read or a write. A request arrives with the requester's privilege level (0 to 3), a read/write flag, the five-field register encoding and write data. The block answers in the same cycle. The request either completes and returns the register value, is flagged as an undefined instruction, or is diverted to a higher privilege level with syndrome class 0x18.

Several controls from the higher levels steer the diversion: whether level 2 is in effect, a host-redirect bit, a monitor trap bit for level 2, whether level 3 exists, and a monitor trap bit for level 3. Each level checks its own ordered set of conditions, and reads and writes follow different rules. Only bit 0 of the 64-bit register holds state. Every other bit reads as zero and ignores writes.

Requests use a valid-only stream. `req_valid` qualifies a request in the cycle it is presented, and `rsp_valid` qualifies the answer in that same cycle. The gate never applies back-pressure, so it has no ready signal. A request is accepted in every cycle in which `req_valid` is high. A completed write takes effect at the next rising clock edge.

Top module: `mon_access_gate`

## Requirements
- R1: A request responds (`rsp_valid`=1) only when `req_valid`=1 and the encoding is op0=2'b11, op1=3'b011, CRn=4'b1101, CRm=4'b0010, op2=3'b011. Otherwise `rsp_valid`, `undef`, `trap_valid`, `trap_level`, `trap_class` and `rdata` are all zero, and the stored enable does not change.
- R2: A synchronous active-high `rst` clears the enable bit to 0.
- R3: A read that completes returns the enable bit in `rdata[0]`, with `rdata[63:1]` zero. `rdata` is zero on any trap, on any undefined request and on any write.
- R4: A read from level 0 with enable=0 traps. The target is level 2 when `lvl2_on`=1 and `host_redir`=1, and level 1 otherwise.
- R5: For a level-0 read with enable=1, and for any level-1 request, the next check is the level-2 trap: if `lvl2_on`=1 and `lvl2_mon_trap`=1, the request traps to level 2.
- R6: A level-0 or level-1 request that passed the earlier checks traps to level 3 if `lvl3_on`=1 and `lvl3_mon_trap`=1. Otherwise it completes.
- R7: A level-2 request traps to level 3 only when `lvl3_on`=1 and `lvl3_mon_trap`=1. A level-3 request always completes.
- R8: Any write from level 0 raises `undef`, never traps, and leaves the enable unchanged. The enable bit never causes a write to trap.
- R9: Writes from levels 1, 2 and 3 go through the same level-2 and level-3 checks as reads. A write that completes loads `wdata[0]` into the enable at the next clock edge, and a trapped write leaves it unchanged.
- R10: Every trap reports `trap_class`=6'h18. When there is no trap, `trap_class` and `trap_level` are 0. `undef` and `trap_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| cur_el | input | 2 | Privilege level of the requester |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| wdata | input | 64 | Write data |
| lvl2_on | input | 1 | Level 2 implemented and in effect |
| host_redir | input | 1 | Redirect level-0 enable traps to level 2 |
| lvl2_mon_trap | input | 1 | Level-2 monitor access trap control |
| lvl3_on | input | 1 | Level 3 implemented |
| lvl3_mon_trap | input | 1 | Level-3 monitor access trap control |
| rsp_valid | output | 1 | Request matched and answered |
| rdata | output | 64 | Read data of a completed read |
| undef | output | 1 | Request is an undefined instruction |
| trap_valid | output | 1 | Request diverted to a higher level |
| trap_level | output | 2 | Target level of the trap |
| trap_class | output | 6 | Syndrome class of the trap |

## Verification
The one stored bit feeds both the level-0 read decision and the read data. If that bit is wrong, the fault shows in the same cycle as a missing or spurious level-0 trap, or as a wrong `rdata[0]` on the next completed read. Either shows within one request after the faulty write or reset. The bench walks every level, direction, enable value and control combination. After each request it reads the bit back from level 3, so a write that updates when it should not, or fails to update when it should, is caught one cycle later. Sweeps of every non-matching value in each encoding field check that a near-miss never changes the bit.

// File: rtl/mag_pkg.sv
package mag_pkg;

  localparam int DATA_W = 64;
  localparam int LVL_W  = 2;
  localparam int SYN_W  = 6;

  typedef enum logic [LVL_W-1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } lvl_t;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sreg_enc_t;

  typedef struct packed {
    logic trap;
    logic undef;
    lvl_t target;
  } verdict_t;

  localparam sreg_enc_t ENC_USER_EN = '{op0: 2'b11, op1: 3'b011, crn: 4'b1101,
                                        crm: 4'b0010, op2: 3'b011};
  localparam logic [SYN_W-1:0] SYN_MON_ACCESS = 6'h18;

endpackage

// File: rtl/mag_enc_match.sv
module mag_enc_match
  import mag_pkg::*;
#(
  parameter sreg_enc_t SEL = ENC_USER_EN
) (
  input  logic      valid,
  input  sreg_enc_t enc,
  output logic      hit
);
  localparam int ENC_W = $bits(sreg_enc_t);

  logic [ENC_W-1:0] diff;

  always_comb diff = enc ^ SEL;

  assign hit = valid && (diff == '0);
endmodule

// File: rtl/mag_route.sv
module mag_route
  import mag_pkg::*;
(
  input  lvl_t     el,
  input  logic     is_write,
  input  logic     en,
  input  logic     lvl2_on,
  input  logic     host_redir,
  input  logic     lvl2_tam,
  input  logic     lvl3_on,
  input  logic     lvl3_tam,
  output verdict_t v
);
  logic chk_l2;
  logic chk_l3;

  always_comb begin
    chk_l2 = lvl2_on && lvl2_tam;
    chk_l3 = lvl3_on && lvl3_tam;
  end

  always_comb begin
    v = '{trap: 1'b0, undef: 1'b0, target: LVL0};
    unique case (el)
      LVL0: begin
        if (is_write) begin
          v.undef = 1'b1;
        end else if (!en) begin
          v.trap   = 1'b1;
          v.target = (lvl2_on && host_redir) ? LVL2 : LVL1;
        end else if (chk_l2) begin
          v.trap   = 1'b1;
          v.target = LVL2;
        end else if (chk_l3) begin
          v.trap   = 1'b1;
          v.target = LVL3;
        end
      end
      LVL1: begin
        if (chk_l2) begin
          v.trap   = 1'b1;
          v.target = LVL2;
        end else if (chk_l3) begin
          v.trap   = 1'b1;
          v.target = LVL3;
        end
      end
      LVL2: begin
        if (chk_l3) begin
          v.trap   = 1'b1;
          v.target = LVL3;
        end
      end
      default: begin
        v.trap = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mag_en_reg.sv
module mag_en_reg #(
  parameter int DATA_W = 64,
  parameter int EN_POS = 0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= RST_VAL;
    end else if (we) begin
      en_q <= wdata[EN_POS];
    end
  end
endmodule

// File: rtl/mon_access_gate.sv
module mon_access_gate
  import mag_pkg::*;
#(
  parameter int EN_POS = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        cur_el,
  input  logic [1:0]        enc_op0,
  input  logic [2:0]        enc_op1,
  input  logic [3:0]        enc_crn,
  input  logic [3:0]        enc_crm,
  input  logic [2:0]        enc_op2,
  input  logic [63:0]       wdata,
  input  logic              lvl2_on,
  input  logic              host_redir,
  input  logic              lvl2_mon_trap,
  input  logic              lvl3_on,
  input  logic              lvl3_mon_trap,
  output logic              rsp_valid,
  output logic [63:0]       rdata,
  output logic              undef,
  output logic              trap_valid,
  output logic [1:0]        trap_level,
  output logic [5:0]        trap_class
);
  sreg_enc_t enc;
  logic      hit;
  logic      en_q;
  logic      wr_commit;
  verdict_t  v;

  always_comb enc = '{op0: enc_op0, op1: enc_op1, crn: enc_crn, crm: enc_crm, op2: enc_op2};

  mag_enc_match #(.SEL(ENC_USER_EN)) u_match (
    .valid (req_valid),
    .enc   (enc),
    .hit   (hit)
  );

  mag_route u_route (
    .el         (lvl_t'(cur_el)),
    .is_write   (req_write),
    .en         (en_q),
    .lvl2_on    (lvl2_on),
    .host_redir (host_redir),
    .lvl2_tam   (lvl2_mon_trap),
    .lvl3_on    (lvl3_on),
    .lvl3_tam   (lvl3_mon_trap),
    .v          (v)
  );

  assign wr_commit = hit && req_write && !v.trap && !v.undef;

  mag_en_reg #(.DATA_W(DATA_W), .EN_POS(EN_POS), .RST_VAL(1'b0)) u_en (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_commit),
    .wdata (wdata),
    .en_q  (en_q)
  );

  always_comb begin
    rsp_valid  = hit;
    undef      = hit && v.undef;
    trap_valid = hit && v.trap;
    trap_level = trap_valid ? v.target : LVL0;
    trap_class = trap_valid ? SYN_MON_ACCESS : '0;
    rdata      = '0;
    if (hit && !req_write && !v.trap && !v.undef) begin
      rdata[EN_POS] = en_q;
    end
  end
endmodule

// File: rtl/mag_chk.sv
module mag_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  cur_el,
  input logic        rsp_valid,
  input logic        undef,
  input logic        trap_valid,
  input logic [5:0]  trap_class,
  input logic [63:0] rdata,
  input logic        wbit,
  input logic        en_q
);
  logic commit;
  assign commit = rsp_valid && req_write && !trap_valid && !undef;

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!rsp_valid && !undef && !trap_valid && rdata == '0));

  // R2
  a_r2_reset_clears: assert property (@(posedge clk) rst |=> !en_q);

  // R3
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[63:1] == '0);

  // R7
  a_r7_top_level_completes: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cur_el == 2'd3) |-> (!trap_valid && !undef));

  // R8
  a_r8_low_write_undef: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && req_write && cur_el == 2'd0) |-> (undef && !trap_valid));

  // R9
  a_r9_commit_loads: assert property (@(posedge clk) disable iff (rst)
    commit |=> (en_q == $past(wbit)));

  a_r9_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(en_q));

  // R10
  a_r10_class_code: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (trap_class == 6'h18));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(trap_valid && undef));
endmodule

bind mon_access_gate mag_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .cur_el     (cur_el),
  .rsp_valid  (rsp_valid),
  .undef      (undef),
  .trap_valid (trap_valid),
  .trap_class (trap_class),
  .rdata      (rdata),
  .wbit       (wdata[0]),
  .en_q       (en_q)
);

// File: tb/mon_access_gate_tb_top.sv
module mon_access_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  cur_el;
  logic [1:0]  enc_op0;
  logic [2:0]  enc_op1;
  logic [3:0]  enc_crn;
  logic [3:0]  enc_crm;
  logic [2:0]  enc_op2;
  logic [63:0] wdata;
  logic        lvl2_on, host_redir, lvl2_mon_trap, lvl3_on, lvl3_mon_trap;
  logic        rsp_valid, undef, trap_valid;
  logic [63:0] rdata;
  logic [1:0]  trap_level;
  logic [5:0]  trap_class;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mon_access_gate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .cur_el(cur_el), .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn),
    .enc_crm(enc_crm), .enc_op2(enc_op2), .wdata(wdata), .lvl2_on(lvl2_on),
    .host_redir(host_redir), .lvl2_mon_trap(lvl2_mon_trap), .lvl3_on(lvl3_on),
    .lvl3_mon_trap(lvl3_mon_trap), .rsp_valid(rsp_valid), .rdata(rdata),
    .undef(undef), .trap_valid(trap_valid), .trap_level(trap_level),
    .trap_class(trap_class)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_enc_ok();
    enc_op0 = 2'b11; enc_op1 = 3'b011; enc_crn = 4'b1101;
    enc_crm = 4'b0010; enc_op2 = 3'b011;
  endtask

  task automatic set_cfg(input logic [4:0] c);
    {lvl2_on, host_redir, lvl2_mon_trap, lvl3_on, lvl3_mon_trap} = c;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; cur_el = 2'd0;
    wdata = '0; set_cfg(5'd0); set_enc_ok();
  endtask

  // Write enable bit from level 3 with no traps configured; takes one edge.
  task automatic put_en(input logic b);
    set_enc_ok(); set_cfg(5'd0);
    req_valid = 1'b1; req_write = 1'b1; cur_el = 2'd3;
    wdata = {63'h5A5A_5A5A_5A5A_5A5A, b};
    @(negedge clk);
    idle();
  endtask

  // Read from level 3 with no traps, returns rdata; combinational.
  task automatic peek(output logic [63:0] v);
    set_enc_ok(); set_cfg(5'd0);
    req_valid = 1'b1; req_write = 1'b0; cur_el = 2'd3;
    #1 v = rdata;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] rv;
    idle();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R2: reset value
    peek(rv);
    check(rv == 64'd0, "R2 reset value", rv, 64'd0);

    // R3: upper bits read zero after writing all ones
    set_enc_ok(); req_valid = 1'b1; req_write = 1'b1; cur_el = 2'd3;
    wdata = '1; @(negedge clk); idle();
    peek(rv);
    check(rv == 64'd1, "R3 upper bits zero", rv, 64'd1);

    // R2: mid-run reset clears
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    peek(rv);
    check(rv == 64'd0, "R2 mid-run reset", rv, 64'd0);

    // R1: valid low with matching encoding writing 1
    put_en(1'b0);
    req_valid = 1'b0; req_write = 1'b1; cur_el = 2'd3; wdata = 64'd1;
    #1 check({rsp_valid, undef, trap_valid, trap_level, trap_class} == '0 && rdata == '0,
             "R1 no valid quiet", {rsp_valid, undef, trap_valid}, 0);
    @(negedge clk); idle();
    peek(rv);
    check(rv == 64'd0, "R1 no valid unchanged", rv, 64'd0);

    // R1: every non-matching value of each encoding field
    for (int f = 0; f < 5; f++) begin
      for (int val = 0; val < 16; val++) begin
        logic skip;
        put_en(1'b0);
        set_enc_ok();
        skip = 1'b0;
        case (f)
          0: if (val < 4 && val != 3) enc_op0 = 2'(val); else skip = 1'b1;
          1: if (val < 8 && val != 3) enc_op1 = 3'(val); else skip = 1'b1;
          2: if (val != 13) enc_crn = 4'(val); else skip = 1'b1;
          3: if (val != 2) enc_crm = 4'(val); else skip = 1'b1;
          default: if (val < 8 && val != 3) enc_op2 = 3'(val); else skip = 1'b1;
        endcase
        if (!skip) begin
          req_valid = 1'b1; req_write = 1'b1; cur_el = 2'd3; wdata = 64'd1;
          #1 check(!rsp_valid && !undef && !trap_valid && trap_class == 0 && rdata == 0,
                   $sformatf("R1 mismatch field %0d val %0d quiet", f, val),
                   {rsp_valid, undef, trap_valid}, 0);
          @(negedge clk); idle();
          peek(rv);
          check(rv == 64'd0, $sformatf("R1 mismatch field %0d val %0d unchanged", f, val),
                rv, 64'd0);
        end
      end
    end

    // R3..R10: full sweep of level, direction, enable, and controls
    for (int e = 0; e < 2; e++) begin
      for (int el = 0; el < 4; el++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int c = 0; c < 32; c++) begin
            logic l2, hr, t2, l3, t3;
            logic exp_trap, exp_undef, exp_en;
            logic [1:0] exp_lvl;
            logic [63:0] exp_rd;
            {l2, hr, t2, l3, t3} = 5'(c);
            exp_trap = 1'b0; exp_undef = 1'b0; exp_lvl = 2'd0;
            if (wr == 1 && el == 0) exp_undef = 1'b1;                       // R8
            else if (el == 0 && wr == 0 && e == 0) begin                     // R4
              exp_trap = 1'b1; exp_lvl = (l2 && hr) ? 2'd2 : 2'd1;
            end else if (el <= 1 && l2 && t2) begin                          // R5
              exp_trap = 1'b1; exp_lvl = 2'd2;
            end else if (el <= 2 && l3 && t3) begin                          // R6 R7
              exp_trap = 1'b1; exp_lvl = 2'd3;
            end
            exp_rd = (!exp_trap && !exp_undef && wr == 0) ? 64'(e) : 64'd0;  // R3
            exp_en = (wr == 1 && !exp_trap && !exp_undef) ? ~e[0] : e[0];    // R9

            put_en(e[0]);
            set_enc_ok(); set_cfg(5'(c));
            req_valid = 1'b1; req_write = wr[0]; cur_el = 2'(el);
            wdata = {63'h7FFF_FFFF_FFFF_FFFF, ~e[0]};
            #1;
            check(rsp_valid && undef == exp_undef && trap_valid == exp_trap &&
                  trap_level == exp_lvl,
                  $sformatf("R4/R5/R6/R7/R8 verdict el=%0d wr=%0d en=%0d cfg=%0h", el, wr, e, c),
                  {rsp_valid, undef, trap_valid, trap_level},
                  {1'b1, exp_undef, exp_trap, exp_lvl});
            check(trap_class == (exp_trap ? 6'h18 : 6'h00),
                  $sformatf("R10 class el=%0d wr=%0d cfg=%0h", el, wr, c),
                  trap_class, exp_trap ? 6'h18 : 6'h00);
            check(rdata == exp_rd, $sformatf("R3 rdata el=%0d wr=%0d en=%0d cfg=%0h", el, wr, e, c),
                  rdata, exp_rd);
            @(negedge clk); idle();
            peek(rv);
            check(rv == 64'(exp_en), $sformatf("R9 stored el=%0d wr=%0d en=%0d cfg=%0h", el, wr, e, c),
                  rv, 64'(exp_en));
          end
        end
      end
    end

    finish_run();
  end
endmodule